// File: doc/BRIEF.md
# Firmware Memory Byte Cycle Target

This block answers single-byte firmware-memory cycles on a 4-bit multiplexed host bus, the kind used to reach boot firmware. It runs on the bus clock. It watches an active-low frame strobe and the four shared data lines. When the host opens a firmware read or firmware write with a matching device-select nibble, the block takes in a 28-bit address sent as seven nibbles and checks that the size nibble asks for one byte. It then runs the rest of the cycle: the turnaround, a configurable run of wait nibbles, the sync nibble, the data nibbles and the closing handback of the bus.

On the local side the block has a simple byte port. A read issues a one-clock read strobe while the host is turning the bus around. The memory must return the byte on the following clock. A write issues a one-clock write strobe once both data nibbles have arrived. The shared lines are presented as separate input, output and output-enable signals, so a pad cell outside the block forms the tri-state driver.

Top module: `fwh_byte_target`

## Requirements
- R1: While reset is high, and on the first clocks after it, the output enable, read strobe and write strobe are all low.
- R2: A cycle starts only on a clock where the frame strobe is low. A start nibble of 1101 (firmware read) or 1110 (firmware write) opens a cycle. Any other start nibble leaves the target silent until the next low frame strobe, even if 1101 or 1110 later appear with the frame strobe high.
- R3: The nibble after the start must equal `dev_id`. Otherwise the target stays silent for the rest of the cycle.
- R4: The seven nibbles after the device select form `mem_addr`, with the most significant nibble first. `mem_addr` holds that value while a read or write strobe is high.
- R5: The size nibble must be 0000. Any other size leaves the target silent for the rest of the cycle.
- R6: On a read, `mem_rd` is high for exactly one clock: the clock after the size nibble. `mem_rdata` is taken at the end of the next clock.
- R7: After the two host turnaround clocks, the target drives 0110 for `wait_cnt` clocks (sampled at the end of the second turnaround clock, zero allowed) and then 0000 for one clock.
- R8: On a read, the two clocks after the sync nibble carry the byte from `mem_rdata`, bits 3:0 first and then bits 7:4.
- R9: On a write, the two clocks after the size nibble carry the data from the host, low nibble first. `mem_wr` is high for exactly one clock, the clock after the high nibble, and `mem_wdata` holds the byte at that time.
- R10: After the last sync or data nibble, the target drives 1111 for one clock. It then releases the lines for one clock and is idle.
- R11: `lad_oe` is high only on wait, sync, read-data and closing-1111 clocks. It is never high on host-driven clocks or float clocks.
- R12: A low frame strobe in the middle of a cycle drops `lad_oe` in that same clock and ends the cycle. The nibble on that clock is read as a new start.
- R13: When the frame strobe is held low for several clocks, only the start nibble on the last low clock decides the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_n | input | 1 | Cycle framing strobe, active low |
| lad_in | input | 4 | Nibble sampled from the shared lines |
| lad_out | output | 4 | Nibble the target places on the lines |
| lad_oe | output | 1 | Output enable for the line drivers |
| dev_id | input | 4 | Device-select value this target answers to |
| wait_cnt | input | WAIT_W | Number of wait nibbles before sync |
| mem_addr | output | 4*ADDR_NIBS | Collected byte address |
| mem_rd | output | 1 | One-clock read strobe |
| mem_rdata | input | 8 | Read byte, valid the clock after mem_rd |
| mem_wr | output | 1 | One-clock write strobe |
| mem_wdata | output | 8 | Byte to write, valid with mem_wr |

## Verification
The hardest case to reach is a frame strobe that falls while the target itself is driving the lines, in the middle of its wait run. The float must then happen in the same clock, and the next cycle must still start cleanly. The stimulus reaches it with a long wait count. It pulls the frame strobe low on the third wait nibble with a non-firmware start code, and then runs a full read. The bench also holds the frame strobe low over several clocks with junk nibbles, and it hides the firmware start codes inside the address of an ignored cycle. These checks show that framing, not the nibble values, decides when a cycle opens.

// File: rtl/fwh_pkg.sv
package fwh_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ID,
        ST_ADDR,
        ST_SIZE,
        ST_WLO,
        ST_WHI,
        ST_HTAR1,
        ST_HTAR2,
        ST_WAIT,
        ST_SYNC,
        ST_RLO,
        ST_RHI,
        ST_TTAR1,
        ST_TTAR2
    } fw_state_e;

    localparam logic [3:0] START_FW_RD   = 4'b1101;
    localparam logic [3:0] START_FW_WR   = 4'b1110;
    localparam logic [3:0] NIB_WAIT      = 4'b0110;
    localparam logic [3:0] NIB_SYNC      = 4'b0000;
    localparam logic [3:0] NIB_TAR       = 4'b1111;
    localparam logic [3:0] SIZE_ONE_BYTE = 4'b0000;

    typedef struct packed {
        logic       oe;
        logic [3:0] val;
    } lad_drive_t;

    typedef struct packed {
        fw_state_e state;
        logic      is_write;
    } cyc_ctx_t;

    // Clocks in which the target owns the shared lines.
    function automatic logic target_owns(fw_state_e s);
        return (s == ST_WAIT) || (s == ST_SYNC) || (s == ST_RLO) ||
               (s == ST_RHI)  || (s == ST_TTAR1);
    endfunction

    // Classify a start nibble sampled while framing is low.
    function automatic cyc_ctx_t decode_start(logic [3:0] nib);
        cyc_ctx_t c;
        c.is_write = 1'b0;
        c.state    = ST_IDLE;
        if (nib == START_FW_RD) begin
            c.state = ST_ID;
        end else if (nib == START_FW_WR) begin
            c.state    = ST_ID;
            c.is_write = 1'b1;
        end
        return c;
    endfunction

endpackage

// File: rtl/fwh_seq.sv
module fwh_seq
    import fwh_pkg::*;
#(
    parameter int ADDR_NIBS = 7,
    parameter int WAIT_W    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_n,
    input  logic [3:0]        lad_in,
    input  logic [3:0]        dev_id,
    input  logic [WAIT_W-1:0] wait_cnt,
    output fw_state_e         state_q,
    output logic              is_write_q
);

    localparam int CNT_W = (ADDR_NIBS > 1) ? $clog2(ADDR_NIBS) : 1;
    localparam logic [CNT_W-1:0] LAST_NIB = CNT_W'(ADDR_NIBS - 1);

    fw_state_e         state_d;
    logic              is_write_d;
    logic [CNT_W-1:0]  nib_cnt_q, nib_cnt_d;
    logic [WAIT_W-1:0] wcnt_q, wcnt_d;
    cyc_ctx_t          start_ctx;

    always_comb begin
        start_ctx  = decode_start(lad_in);
        state_d    = state_q;
        is_write_d = is_write_q;
        nib_cnt_d  = nib_cnt_q;
        wcnt_d     = wcnt_q;
        if (!frame_n) begin
            // Framing low: abort anything in flight and read a start code.
            state_d    = start_ctx.state;
            is_write_d = start_ctx.is_write;
            nib_cnt_d  = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_ID: begin
                    nib_cnt_d = '0;
                    state_d   = (lad_in == dev_id) ? ST_ADDR : ST_IDLE;
                end
                ST_ADDR: begin
                    if (nib_cnt_q == LAST_NIB) begin
                        state_d = ST_SIZE;
                    end else begin
                        nib_cnt_d = nib_cnt_q + 1'b1;
                    end
                end
                ST_SIZE: begin
                    if (lad_in != SIZE_ONE_BYTE) begin
                        state_d = ST_IDLE;
                    end else begin
                        state_d = is_write_q ? ST_WLO : ST_HTAR1;
                    end
                end
                ST_WLO:   state_d = ST_WHI;
                ST_WHI:   state_d = ST_HTAR1;
                ST_HTAR1: state_d = ST_HTAR2;
                ST_HTAR2: begin
                    wcnt_d  = wait_cnt;
                    state_d = (wait_cnt == '0) ? ST_SYNC : ST_WAIT;
                end
                ST_WAIT: begin
                    if (wcnt_q <= WAIT_W'(1)) begin
                        state_d = ST_SYNC;
                    end else begin
                        wcnt_d = wcnt_q - 1'b1;
                    end
                end
                ST_SYNC:  state_d = is_write_q ? ST_TTAR1 : ST_RLO;
                ST_RLO:   state_d = ST_RHI;
                ST_RHI:   state_d = ST_TTAR1;
                ST_TTAR1: state_d = ST_TTAR2;
                ST_TTAR2: state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            is_write_q <= 1'b0;
            nib_cnt_q  <= '0;
            wcnt_q     <= '0;
        end else begin
            state_q    <= state_d;
            is_write_q <= is_write_d;
            nib_cnt_q  <= nib_cnt_d;
            wcnt_q     <= wcnt_d;
        end
    end

endmodule

// File: rtl/fwh_data.sv
module fwh_data
    import fwh_pkg::*;
#(
    parameter int ADDR_NIBS = 7,
    parameter int ADDR_W    = 4 * ADDR_NIBS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_n,
    input  fw_state_e         state_q,
    input  logic [3:0]        lad_in,
    input  logic [7:0]        mem_rdata,
    output logic [ADDR_W-1:0] addr_q,
    output logic [7:0]        wdata_q,
    output logic [7:0]        rdata_q
);

    logic [ADDR_W-1:0] addr_shift;

    generate
        if (ADDR_W > 4) begin : g_shift_wide
            assign addr_shift = {addr_q[ADDR_W-5:0], lad_in};
        end else begin : g_shift_narrow
            assign addr_shift = lad_in;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else if (frame_n) begin
            unique case (state_q)
                ST_ADDR:  addr_q        <= addr_shift;
                ST_WLO:   wdata_q[3:0]  <= lad_in;
                ST_WHI:   wdata_q[7:4]  <= lad_in;
                ST_HTAR2: rdata_q       <= mem_rdata;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/fwh_lad_drv.sv
module fwh_lad_drv
    import fwh_pkg::*;
(
    input  fw_state_e  state_q,
    input  logic       is_write_q,
    input  logic       frame_n,
    input  logic [7:0] rdata_q,
    output lad_drive_t drive
);

    always_comb begin
        drive.val = NIB_TAR;
        unique case (state_q)
            ST_WAIT:  drive.val = NIB_WAIT;
            ST_SYNC:  drive.val = NIB_SYNC;
            ST_RLO:   drive.val = is_write_q ? NIB_TAR : rdata_q[3:0];
            ST_RHI:   drive.val = is_write_q ? NIB_TAR : rdata_q[7:4];
            default:  drive.val = NIB_TAR;
        endcase
        // Framing low releases the lines in the same clock.
        drive.oe = target_owns(state_q) && frame_n;
    end

endmodule

// File: rtl/fwh_byte_target.sv
module fwh_byte_target
    import fwh_pkg::*;
#(
    parameter int ADDR_NIBS = 7,
    parameter int WAIT_W    = 4,
    localparam int ADDR_W   = 4 * ADDR_NIBS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_n,
    input  logic [3:0]        lad_in,
    output logic [3:0]        lad_out,
    output logic              lad_oe,
    input  logic [3:0]        dev_id,
    input  logic [WAIT_W-1:0] wait_cnt,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [7:0]        mem_rdata,
    output logic              mem_wr,
    output logic [7:0]        mem_wdata
);

    fw_state_e  state_q;
    logic       is_write_q;
    logic [7:0] rdata_q;
    lad_drive_t drive;

    fwh_seq #(
        .ADDR_NIBS (ADDR_NIBS),
        .WAIT_W    (WAIT_W)
    ) seq_i (
        .clk        (clk),
        .rst        (rst),
        .frame_n    (frame_n),
        .lad_in     (lad_in),
        .dev_id     (dev_id),
        .wait_cnt   (wait_cnt),
        .state_q    (state_q),
        .is_write_q (is_write_q)
    );

    fwh_data #(
        .ADDR_NIBS (ADDR_NIBS),
        .ADDR_W    (ADDR_W)
    ) data_i (
        .clk       (clk),
        .rst       (rst),
        .frame_n   (frame_n),
        .state_q   (state_q),
        .lad_in    (lad_in),
        .mem_rdata (mem_rdata),
        .addr_q    (mem_addr),
        .wdata_q   (mem_wdata),
        .rdata_q   (rdata_q)
    );

    fwh_lad_drv drv_i (
        .state_q    (state_q),
        .is_write_q (is_write_q),
        .frame_n    (frame_n),
        .rdata_q    (rdata_q),
        .drive      (drive)
    );

    assign lad_out = drive.val;
    assign lad_oe  = drive.oe;

    // First host-turnaround clock: launch the read, or commit the write.
    assign mem_rd = frame_n && (state_q == ST_HTAR1) && !is_write_q;
    assign mem_wr = frame_n && (state_q == ST_HTAR1) &&  is_write_q;

endmodule

// File: rtl/fwh_target_chk.sv
module fwh_target_chk
    import fwh_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       frame_n,
    input logic [3:0] lad_out,
    input logic       lad_oe,
    input logic       mem_rd,
    input logic       mem_wr,
    input fw_state_e  state_q
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!lad_oe && !mem_rd && !mem_wr));                              // R1

    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd);                                                   // R6

    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> !mem_wr);                                                   // R9

    AST_NO_RD_WITH_WR: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));                                                  // R6

    AST_WAIT_PATTERN: assert property (@(posedge clk) disable iff (rst)
        (lad_oe && state_q == ST_WAIT) |-> (lad_out == NIB_WAIT));             // R7

    AST_HANDBACK_FLOAT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TTAR1 && frame_n) |=> !lad_oe);                         // R10

    AST_HOST_PHASE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HTAR1 || state_q == ST_HTAR2 || state_q == ST_ADDR)
            |-> !lad_oe);                                                      // R11

    AST_FRAME_RELEASES: assert property (@(posedge clk) disable iff (rst)
        !frame_n |-> !lad_oe);                                                 // R12

endmodule

bind fwh_byte_target fwh_target_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .frame_n (frame_n),
    .lad_out (lad_out),
    .lad_oe  (lad_oe),
    .mem_rd  (mem_rd),
    .mem_wr  (mem_wr),
    .state_q (state_q)
);

// File: tb/fwh_byte_target_tb_top.sv
module fwh_byte_target_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        frame_n;
    logic [3:0]  host_lad;
    logic [3:0]  lad_in;
    logic [3:0]  lad_out;
    logic        lad_oe;
    logic [3:0]  dev_id;
    logic [3:0]  wait_cnt;
    logic [27:0] mem_addr;
    logic        mem_rd;
    logic [7:0]  mem_rdata;
    logic        mem_wr;
    logic [7:0]  mem_wdata;

    always #10 clk = ~clk;

    // Shared lines: target when enabled, otherwise host or pull-ups.
    assign lad_in = lad_oe ? lad_out : host_lad;

    fwh_byte_target dut_i (
        .clk       (clk),
        .rst       (rst),
        .frame_n   (frame_n),
        .lad_in    (lad_in),
        .lad_out   (lad_out),
        .lad_oe    (lad_oe),
        .dev_id    (dev_id),
        .wait_cnt  (wait_cnt),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_rdata (mem_rdata),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata)
    );

    // Local byte memory with one clock of read latency.
    logic [7:0] mem [256];
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    end

    typedef struct {
        bit         fr;
        logic [3:0] nib;
        logic [3:0] wc;
    } stim_t;

    typedef struct {
        bit          oe;
        logic [3:0]  out;
        bit          rd;
        bit          wr;
        logic [27:0] addr;
        logic [7:0]  wd;
        string       req;
    } exp_t;

    stim_t      sq[$];
    exp_t       eq[$];
    logic [7:0] ref_mem [256];
    int         errors = 0;
    int         checks = 0;
    bit         done   = 0;
    logic [3:0] cur_wc;

    function automatic exp_t quiet(string r);
        exp_t e;
        e.oe = 0; e.out = 4'h0; e.rd = 0; e.wr = 0;
        e.addr = '0; e.wd = '0; e.req = r;
        return e;
    endfunction

    function automatic exp_t drv(logic [3:0] v, string r);
        exp_t e = quiet(r);
        e.oe  = 1;
        e.out = v;
        return e;
    endfunction

    task automatic push(bit fr, logic [3:0] nib, exp_t e);
        stim_t s;
        s.fr = fr; s.nib = nib; s.wc = cur_wc;
        sq.push_back(s);
        eq.push_back(e);
    endtask

    task automatic check(exp_t e);
        bit bad;
        checks++;
        bad = (lad_oe !== e.oe) || (e.oe && lad_out !== e.out) ||
              (mem_rd !== e.rd) || (mem_wr !== e.wr) ||
              ((e.rd || e.wr) && mem_addr !== e.addr) ||
              (e.wr && mem_wdata !== e.wd);
        if (bad) begin
            errors++;
            $display("FAIL %s: got oe=%0b out=%h rd=%0b wr=%0b addr=%h wd=%h, expected oe=%0b out=%h rd=%0b wr=%0b addr=%h wd=%h",
                     e.req, lad_oe, lad_out, mem_rd, mem_wr, mem_addr, mem_wdata,
                     e.oe, e.out, e.rd, e.wr, e.addr, e.wd);
        end
    endtask

    task automatic run_queue();
        while (sq.size() > 0) begin
            stim_t s;
            exp_t  e;
            @(negedge clk);
            s        = sq.pop_front();
            frame_n  = s.fr;
            host_lad = s.nib;
            wait_cnt = s.wc;
            #8;
            e = eq.pop_front();
            check(e);
        end
    endtask

    // Builds host stimulus and the expected per-clock target response.
    task automatic fw_cycle(logic [3:0] start, logic [3:0] id, logic [27:0] addr,
                            logic [3:0] size, logic [7:0] wdat, int waits,
                            int pre_frames, int abort_at, bit resp, string req);
        bit   wr = (start == 4'b1110);
        exp_t e;
        cur_wc = 4'(waits);
        for (int i = 0; i < pre_frames; i++) push(0, 4'h0, quiet("R13"));
        push(0, start, quiet(req));
        push(1, id, quiet("R3"));
        for (int i = 6; i >= 0; i--) push(1, addr[i*4 +: 4], quiet("R11"));
        push(1, size, quiet("R11"));
        if (!resp) begin
            for (int i = 0; i < 12; i++) push(1, 4'hF, quiet(req));
            run_queue();
            return;
        end
        if (wr) begin
            push(1, wdat[3:0], quiet("R11"));
            push(1, wdat[7:4], quiet("R11"));
            e = quiet("R9 R4"); e.wr = 1; e.addr = addr; e.wd = wdat;
            push(1, 4'hF, e);
            ref_mem[addr[7:0]] = wdat;
        end else begin
            e = quiet("R6 R4"); e.rd = 1; e.addr = addr;
            push(1, 4'hF, e);
        end
        push(1, 4'hF, quiet("R11"));
        for (int i = 0; i < waits; i++) begin
            if (i == abort_at) begin
                push(0, 4'h0, quiet("R12"));
                push(1, 4'hF, quiet("R12"));
                push(1, 4'hF, quiet("R12"));
                run_queue();
                return;
            end
            push(1, 4'hF, drv(4'h6, "R7"));
        end
        push(1, 4'hF, drv(4'h0, "R7"));
        if (!wr) begin
            push(1, 4'hF, drv(ref_mem[addr[7:0]][3:0], "R8"));
            push(1, 4'hF, drv(ref_mem[addr[7:0]][7:4], "R8"));
        end
        push(1, 4'hF, drv(4'hF, "R10"));
        push(1, 4'hF, quiet("R10"));
        push(1, 4'hF, quiet("R10"));
        run_queue();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R11 watchdog: got run still active, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i]     = 8'(i * 37 + 11);
            ref_mem[i] = 8'(i * 37 + 11);
        end
        rst = 1; frame_n = 1; host_lad = 4'hF; wait_cnt = 0; dev_id = 4'h5;
        cur_wc = 0;
        repeat (3) @(negedge clk);
        #8;
        check(quiet("R1"));
        @(negedge clk);
        rst = 0;
        push(1, 4'hF, quiet("R1"));
        push(1, 4'hF, quiet("R1"));
        run_queue();

        // Plain reads, no waits and several waits.
        fw_cycle(4'b1101, 4'h5, 28'h12345A7, 4'h0, 8'h00, 0, 0, -1, 1, "R2");
        fw_cycle(4'b1101, 4'h5, 28'hFEDCB3C, 4'h0, 8'h00, 3, 0, -1, 1, "R2");
        // Write then read the same byte back.
        fw_cycle(4'b1110, 4'h5, 28'h0ABCD3C, 4'h0, 8'hC9, 2, 0, -1, 1, "R2");
        fw_cycle(4'b1101, 4'h5, 28'h0ABCD3C, 4'h0, 8'h00, 1, 0, -1, 1, "R9");
        // Wrong device select.
        fw_cycle(4'b1101, 4'h6, 28'h0000010, 4'h0, 8'h00, 0, 0, -1, 0, "R3");
        // Non-firmware start with firmware codes buried in the address.
        fw_cycle(4'b0000, 4'h5, 28'hDEDEDED, 4'h0, 8'h00, 0, 0, -1, 0, "R2");
        // Multi-byte size is ignored.
        fw_cycle(4'b1101, 4'h5, 28'h0000020, 4'h1, 8'h00, 0, 0, -1, 0, "R5");
        // Abort during the target's wait run, then a clean read.
        fw_cycle(4'b1101, 4'h5, 28'h0000033, 4'h0, 8'h00, 5, 0, 2, 1, "R12");
        fw_cycle(4'b1101, 4'h5, 28'h0000033, 4'h0, 8'h00, 0, 0, -1, 1, "R12");
        // Long frame with junk before the real start code.
        fw_cycle(4'b1101, 4'h5, 28'h9876544, 4'h0, 8'h00, 4, 2, -1, 1, "R13");
        // Write with high nibble F, no waits, then read back.
        fw_cycle(4'b1110, 4'h5, 28'h00000FF, 4'h0, 8'hF0, 0, 0, -1, 1, "R9");
        fw_cycle(4'b1101, 4'h5, 28'h00000FF, 4'h0, 8'h00, 0, 0, -1, 1, "R8");
        // Maximum wait count.
        fw_cycle(4'b1110, 4'h5, 28'h7000001, 4'h0, 8'h5A, 15, 0, -1, 1, "R7");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule